// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Scheduler

This block keeps an asynchronous DRAM alive. After reset it holds the memory bus through a power-up pause and a fixed number of warm-up refresh cycles, and only then raises its init-done flag. From then on an interval timer posts one refresh request per interval. Requests that cannot be served at once are held in a saturating backlog counter. The access sequencer sees the request. The block takes the strobes as soon as the sequencer reports idle, and it keeps the busy flag high for as long as it owns the strobes. The sequencer's strobe multiplexer follows the busy flag.

Two refresh styles are selectable by a mode input. In the default style the column strobe falls before the row strobe, so the memory uses its internal row counter and no address is needed. In the alternative style the block drives a row address from its own counter with the row strobe only, and it steps that counter through every row. The counter wraps at the row count. All pulse widths and the timer interval are parameters in clock cycles. This covers both the 64 ms and the 128 ms retention variants.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and straight after reset ras_no, cas_no and we_no are high, busy_o is high, init_done_o and req_o are low, and addr_o is zero.
- R2: No strobe falls before INIT_WAIT_CYC clock cycles have passed since reset was released.
- R3: After the pause exactly INIT_REFRESHES refresh cycles are issued, and then init_done_o goes high and stays high. busy_o stays high over the whole initialisation.
- R4: In a column-first cycle cas_no falls exactly T_CSR cycles before ras_no falls, and cas_no stays low until ras_no rises. cas_no never falls while ras_no is low.
- R5: ras_no stays low for exactly T_RAS cycles per refresh. Both strobes are then high for at least T_RP cycles before either strobe falls again.
- R6: we_no is high at all times, so no refresh is taken as a write.
- R7: After init the timer posts one request every INTERVAL_CYC cycles. With seq_idle_i held high, exactly one refresh is issued per interval.
- R8: While seq_idle_i is low, the block issues no refresh and busy_o stays low. req_o is high, and requests are counted up to BACKLOG_MAX.
- R9: When seq_idle_i returns high, the counted requests are served back to back, one refresh start every T_CSR+T_RAS+T_RP+1 cycles.
- R10: When ras_only_i is high at the start of a cycle, that cycle keeps cas_no high and drives addr_o with the row counter while ras_no is low. The row counter advances by one per such cycle, modulo 2^ROW_W (4095 is followed by 0). In column-first cycles addr_o is zero.
- R11: busy_o is high whenever ras_no or cas_no is low. A refresh after init starts only when seq_idle_i was high at the starting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | 1 selects row-address refresh for the next cycle, 0 selects column-first refresh |
| seq_idle_i | input | 1 | Access sequencer is idle; acts as the bus grant |
| req_o | output | 1 | At least one refresh request is pending |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe (both byte strobes), active low |
| we_no | output | 1 | Write enable, active low, held high |
| addr_o | output | ROW_W | Row address for row-address refresh, zero otherwise |
| busy_o | output | 1 | Block owns the strobes |
| init_done_o | output | 1 | Power-up pause and warm-up refreshes are complete |

## Verification
A timer tick can fall in the same cycle as a refresh start that drains the backlog. The counter must then neither lose the tick nor overrun its limit. The bench provokes this by holding the sequencer busy for ten intervals, so the backlog is full, and then releasing it. New ticks then arrive while the stored requests are served. It judges the result by counting four refresh starts at the back-to-back spacing in the drain window, with req_o still high and the strobe timing unchanged. A row-address wrap is also driven through more than 4096 cycles, to check the address sequence across the 4095 to 0 boundary.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [2:0] {
    ST_WAIT   = 3'd0,
    ST_IDLE   = 3'd1,
    ST_SETUP  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_PRECH  = 3'd4
  } ref_state_e;
endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
  parameter int unsigned INTERVAL_CYC = 3900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(INTERVAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
  parameter int unsigned BACKLOG_MAX = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic take_i,
  output logic pend_o
);
  localparam int unsigned BW = $clog2(BACKLOG_MAX + 1);
  localparam logic [BW-1:0] FULL = BW'(BACKLOG_MAX);

  logic [BW-1:0] cnt_q;
  logic          inc, dec;

  // a take frees a slot in the same cycle, so a coincident tick is kept
  assign dec    = take_i && (cnt_q != '0);
  assign inc    = tick_i && ((cnt_q != FULL) || dec);
  assign pend_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + BW'(inc) - BW'(dec);
  end
endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_o <= '0;
    else if (step_i) row_o <= row_o + 1'b1;
  end
endmodule

// File: rtl/ref_strobe_fsm.sv
module ref_strobe_fsm
  import dram_ref_pkg::*;
#(
  parameter int unsigned INIT_WAIT_CYC  = 50000,
  parameter int unsigned INIT_REFRESHES = 8,
  parameter int unsigned T_CSR          = 2,
  parameter int unsigned T_RAS          = 13,
  parameter int unsigned T_RP           = 8,
  parameter int unsigned T_ASR          = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_only_i,
  input  logic start_ok_i,
  output logic take_o,
  output logic step_o,
  output logic ras_no,
  output logic cas_no,
  output logic addr_en_o,
  output logic busy_o,
  output logic init_done_o
);
  localparam int unsigned PH_W = $clog2(INIT_WAIT_CYC + T_CSR + T_RAS + T_RP + T_ASR + 1);
  localparam int unsigned IC_W = $clog2(INIT_REFRESHES + 1);
  localparam logic [PH_W-1:0] PH_WAIT = PH_W'(INIT_WAIT_CYC - 1);
  localparam logic [PH_W-1:0] PH_CSR  = PH_W'(T_CSR - 1);
  localparam logic [PH_W-1:0] PH_ASR  = PH_W'(T_ASR - 1);
  localparam logic [PH_W-1:0] PH_RAS  = PH_W'(T_RAS - 1);
  localparam logic [PH_W-1:0] PH_RP   = PH_W'(T_RP - 1);
  localparam logic [IC_W-1:0] IC_LAST = IC_W'(INIT_REFRESHES - 1);

  ref_state_e      state_q, state_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [IC_W-1:0] ic_q, ic_d;
  logic            done_q, done_d;
  logic            ror_q, ror_d;
  logic            strobe_phase;

  function automatic logic [PH_W-1:0] setup_len(input logic ror);
    return ror ? PH_ASR : PH_CSR;
  endfunction

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q - 1'b1;
    ic_d    = ic_q;
    done_d  = done_q;
    ror_d   = ror_q;
    take_o  = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      ST_WAIT: if (ph_q == '0) begin
        state_d = ST_SETUP;
        ph_d    = setup_len(ras_only_i);
        ror_d   = ras_only_i;
      end
      ST_IDLE: begin
        ph_d = ph_q;
        if (start_ok_i) begin
          take_o  = 1'b1;
          state_d = ST_SETUP;
          ph_d    = setup_len(ras_only_i);
          ror_d   = ras_only_i;
        end
      end
      ST_SETUP: if (ph_q == '0) begin
        state_d = ST_ACTIVE;
        ph_d    = PH_RAS;
      end
      ST_ACTIVE: if (ph_q == '0) begin
        state_d = ST_PRECH;
        ph_d    = PH_RP;
        step_o  = ror_q;
      end
      ST_PRECH: if (ph_q == '0) begin
        if (done_q) begin
          state_d = ST_IDLE;
        end else if (ic_q == IC_LAST) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          ic_d    = ic_q + 1'b1;
          state_d = ST_SETUP;
          ph_d    = setup_len(ras_only_i);
          ror_d   = ras_only_i;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      ph_q    <= PH_WAIT;
      ic_q    <= '0;
      done_q  <= 1'b0;
      ror_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      ic_q    <= ic_d;
      done_q  <= done_d;
      ror_q   <= ror_d;
    end
  end

  assign strobe_phase = (state_q == ST_SETUP) || (state_q == ST_ACTIVE);
  assign ras_no       = (state_q != ST_ACTIVE);
  assign cas_no       = !(strobe_phase && !ror_q);
  assign addr_en_o    = strobe_phase && ror_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign init_done_o  = done_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned ROW_W          = 12,
  parameter int unsigned INIT_WAIT_CYC  = 50000,
  parameter int unsigned INIT_REFRESHES = 8,
  parameter int unsigned INTERVAL_CYC   = 3900,
  parameter int unsigned BACKLOG_MAX    = 4,
  parameter int unsigned T_CSR          = 2,
  parameter int unsigned T_RAS          = 13,
  parameter int unsigned T_RP           = 8,
  parameter int unsigned T_ASR          = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_only_i,
  input  logic             seq_idle_i,
  output logic             req_o,
  output logic             ras_no,
  output logic             cas_no,
  output logic             we_no,
  output logic [ROW_W-1:0] addr_o,
  output logic             busy_o,
  output logic             init_done_o
);
  logic             tick, pend, take, step, addr_en;
  logic [ROW_W-1:0] row;

  ref_tick_gen #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (init_done_o),
    .tick_o(tick)
  );

  ref_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .take_i(take),
    .pend_o(pend)
  );

  ref_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step),
    .row_o (row)
  );

  ref_strobe_fsm #(
    .INIT_WAIT_CYC (INIT_WAIT_CYC),
    .INIT_REFRESHES(INIT_REFRESHES),
    .T_CSR         (T_CSR),
    .T_RAS         (T_RAS),
    .T_RP          (T_RP),
    .T_ASR         (T_ASR)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_only_i (ras_only_i),
    .start_ok_i (pend && seq_idle_i),
    .take_o     (take),
    .step_o     (step),
    .ras_no     (ras_no),
    .cas_no     (cas_no),
    .addr_en_o  (addr_en),
    .busy_o     (busy_o),
    .init_done_o(init_done_o)
  );

  assign req_o  = pend;
  assign we_no  = 1'b1;
  assign addr_o = addr_en ? row : '0;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned T_RAS = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             seq_idle_i,
  input logic             ras_no,
  input logic             cas_no,
  input logic [ROW_W-1:0] addr_o,
  input logic             busy_o,
  input logic             init_done_o
);
  logic [15:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lo_cnt <= '0;
    else if (ras_no) lo_cnt <= '0;
    else             lo_cnt <= lo_cnt + 1'b1;
  end

  p_cas_falls_ras_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> ras_no);

  p_ras_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |-> (lo_cnt == 16'(T_RAS)));

  p_cbr_no_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> (addr_o == '0));

  p_busy_covers_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no || !cas_no) |-> busy_o);

  p_grant_by_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && init_done_o) |-> $past(seq_idle_i));

  p_init_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROW_W(ROW_W), .T_RAS(T_RAS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .seq_idle_i (seq_idle_i),
  .ras_no     (ras_no),
  .cas_no     (cas_no),
  .addr_o     (addr_o),
  .busy_o     (busy_o),
  .init_done_o(init_done_o)
);

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;
  localparam int ROW_W    = 12;
  localparam int INIT_W   = 50;
  localparam int INIT_N   = 8;
  localparam int INTV     = 20;
  localparam int BL_MAX   = 4;
  localparam int TCSR     = 2;
  localparam int TRAS     = 4;
  localparam int TRP      = 3;
  localparam int TASR     = 1;
  localparam int SPACING  = TCSR + TRAS + TRP + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_only = 1'b0;
  logic seq_idle = 1'b1;
  logic req, ras_n, cas_n, we_n, busy, init_done;
  logic [ROW_W-1:0] addr;

  always #2 clk = ~clk;

  dram_refresh_sched #(
    .ROW_W(ROW_W), .INIT_WAIT_CYC(INIT_W), .INIT_REFRESHES(INIT_N),
    .INTERVAL_CYC(INTV), .BACKLOG_MAX(BL_MAX), .T_CSR(TCSR), .T_RAS(TRAS),
    .T_RP(TRP), .T_ASR(TASR)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .ras_only_i(ras_only), .seq_idle_i(seq_idle),
    .req_o(req), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .addr_o(addr),
    .busy_o(busy), .init_done_o(init_done)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string req_tag, input int act, input int lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s actual=%0d expected>=%0d", req_tag, act, lim);
    end
  endtask

  // ---- port monitor ----
  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc++;

  logic p_ras = 1'b1, p_cas = 1'b1, in_cbr = 1'b0, have_rise = 1'b0;
  int first_cas = -1, cas_fall_cyc = 0, ras_fall_cyc = 0, ras_rise_cyc = 0;
  int ras_falls = 0, cas_falls = 0, ror_falls = 0, wrap_addr = -1;
  int v_csr = 0, v_chr = 0, v_ras = 0, v_prech = 0, v_we = 0, v_busy = 0;
  int v_addr = 0, v_addr0 = 0;
  logic [ROW_W-1:0] exp_row = '0;

  always @(negedge clk) if (rst_n) begin
    if (!we_n) v_we++;
    if ((!ras_n || !cas_n) && !busy) v_busy++;
    if (!cas_n && addr != '0) v_addr0++;
    if (!ras_n && in_cbr && cas_n) v_chr++;
    if (p_cas && !cas_n) begin
      cas_falls++;
      cas_fall_cyc = cyc;
      if (first_cas < 0) first_cas = cyc;
      if (have_rise && (cyc - ras_rise_cyc) < TRP) v_prech++;
    end
    if (p_ras && !ras_n) begin
      ras_falls++;
      ras_fall_cyc = cyc;
      if (first_cas < 0) first_cas = cyc;
      if (have_rise && (cyc - ras_rise_cyc) < TRP) v_prech++;
      if (!cas_n) begin
        in_cbr = 1'b1;
        if (cyc - cas_fall_cyc != TCSR) v_csr++;
      end else begin
        in_cbr = 1'b0;
        ror_falls++;
        if (addr != exp_row) v_addr++;
        exp_row = exp_row + 1'b1;
        if (ror_falls == (1 << ROW_W) + 1) wrap_addr = int'(addr);
      end
    end
    if (!p_ras && ras_n) begin
      if (cyc - ras_fall_cyc != TRAS) v_ras++;
      ras_rise_cyc = cyc;
      have_rise = 1'b1;
      in_cbr = 1'b0;
    end
    p_ras = ras_n;
    p_cas = cas_n;
  end

  // ---- scenarios ----
  task automatic t_reset();
    #1;
    chk("R1 ras_no", int'(ras_n), 1);
    chk("R1 cas_no", int'(cas_n), 1);
    chk("R1 we_no", int'(we_n), 1);
    chk("R1 busy_o", int'(busy), 1);
    chk("R1 init_done_o", int'(init_done), 0);
    chk("R1 req_o", int'(req), 0);
    chk("R1 addr_o", int'(addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", int'(busy), 1);
  endtask

  task automatic t_init();
    int guard = 0;
    bit busy_dropped = 1'b0;
    while (!init_done && guard < 2000) begin
      @(negedge clk);
      if (!busy && !init_done) busy_dropped = 1'b1;
      guard++;
    end
    chk("R3 init completes", int'(init_done), 1);
    chk_ge("R2 first strobe after pause", first_cas, INIT_W);
    chk("R3 warm-up refresh count", ras_falls, INIT_N);
    chk("R3 busy held during init", int'(busy_dropped), 0);
  endtask

  task automatic t_periodic();
    int base;
    seq_idle = 1'b1;
    repeat (3 * INTV) @(negedge clk);
    base = ras_falls;
    repeat (10 * INTV) @(negedge clk);
    chk("R7 one refresh per interval", ras_falls - base, 10);
    chk("R3 init_done sticky", int'(init_done), 1);
  endtask

  task automatic t_backlog();
    int base;
    bit took = 1'b0;
    seq_idle = 1'b0;
    repeat (SPACING + 2) @(negedge clk);
    base = ras_falls;
    for (int i = 0; i < 10 * INTV; i++) begin
      @(negedge clk);
      if (busy) took = 1'b1;
    end
    chk("R8 no refresh while sequencer busy", ras_falls - base, 0);
    chk("R8 busy_o low while not granted", int'(took), 0);
    chk("R8 req_o pending", int'(req), 1);
    base = ras_falls;
    seq_idle = 1'b1;
    repeat (3 * SPACING + TCSR + 5) @(negedge clk);
    chk("R9 backlog drained back to back", ras_falls - base, BL_MAX);
  endtask

  task automatic t_ras_only();
    int guard = 0;
    int cbase;
    ras_only = 1'b1;
    while (ror_falls < 1 && guard < 1000) begin @(negedge clk); guard++; end
    cbase = cas_falls;
    guard = 0;
    while (ror_falls < (1 << ROW_W) + 1 && guard < 100000) begin @(negedge clk); guard++; end
    chk_ge("R10 row cycles issued", ror_falls, (1 << ROW_W) + 1);
    chk("R10 cas_no held high in row mode", cas_falls - cbase, 0);
    chk("R10 row address sequence", v_addr, 0);
    chk("R10 row wrap 4095 to 0", wrap_addr, 0);
    ras_only = 1'b0;
    repeat (3 * INTV) @(negedge clk);
  endtask

  task automatic t_timing();
    int base = ras_falls;
    repeat (2 * INTV) @(negedge clk);
    chk_ge("R4 column-first cycle after mode return", ras_falls - base, 1);
    chk("R4 cas to ras setup", v_csr, 0);
    chk("R4 cas held through ras low", v_chr, 0);
    chk("R5 ras low width", v_ras, 0);
    chk("R5 precharge", v_prech, 0);
    chk("R6 we_no high", v_we, 0);
    chk("R10 column-first address zero", v_addr0, 0);
    chk("R11 busy covers strobes", v_busy, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_periodic();
    t_backlog();
    t_ras_only();
    t_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule